// File: doc/BRIEF.md
# Reverse Power-Off Cascade Sequencer

This controller turns a group of supply channels off one sequence position at a time. It starts at the highest-numbered position and works down to position 0, which reverses the power-up order. Each channel belongs to one position and has its own off-delay. When the controller enters a position, it counts down each member's delay and then drops that member's enable. It moves to the next lower position only after every member has its enable dropped and its comparator reports the supply below its OFF threshold.

A shutdown starts in one of three ways: the power-on request level falls, software sends an off command while the request is still high, or any channel reports a fault. A per-position stall timer restarts at every position. If it runs out before the position clears, the whole sequence aborts and every enable drops at once. While a sequence runs, the reset output is held asserted and the healthy output is held deasserted. A sequence that runs to the end raises a completion flag. All delays are counted in ticks of a prescaled 1 ms time base.

Top module: `pwroff_cascade_seq`

## Requirements
- R1: During and after reset, with no request, all `chEnable` bits are 0, `rstOutN` is 0, `healthy` is 0, and `seqDone` and `seqAbort` are 0.
- R2: A rising edge on `pwrOnReq` while the block is off brings it to the running state one cycle later. In the running state all `chEnable` bits are 1, `rstOutN` is 1, `healthy` is 1 and `seqDone` is 0.
- R3: In the running state, any of these starts a sequence at the next clock edge: `pwrOnReq` low, a `swOffCmd` pulse, or any `chFault` bit high.
- R4: Positions are served from `NUM_POS-1` down to 0. Channel i takes its position from `chPosFlat[i*POS_W +: POS_W]`. A channel's enable drops only while its own position is being served, or on an abort.
- R5: On entering a position, each member loads its delay from `chOffDlyFlat[i*DLY_W +: DLY_W]`. The delay counts down one per tick, and the enable drops when the count reaches zero.
- R6: The block moves to a lower position only when every member of the current position has its enable at 0 and its `chBelowOff` at 1.
- R7: If the stall timer expires first, all enables drop in the same cycle, `seqAbort` is set, `seqDone` stays 0, and the block goes off.
- R8: `sttSel` selects the stall limit: 0 means no limit, 1 means `STT_UNIT` ticks, 2 means 2×`STT_UNIT` ticks, and 3 means 4×`STT_UNIT` ticks. When `sttOffEn` is 0, the timer never aborts.
- R9: From the edge that starts a sequence until the block returns to running, `rstOutN` is 0 and `healthy` is 0.
- R10: While a sequence runs, changes on `pwrOnReq` and pulses on `forceOff` have no effect. A sequence started by the software command does not restart the supplies on its own when it ends.
- R11: `seqDone` rises when position 0 clears. It stays high while the block is off and clears when the block returns to running.
- R12: A position with no members takes exactly one cycle. With every channel at position 0 and zero delays, the enables drop 6 clock edges after the trigger is sampled when `NUM_POS`=4, and 3 edges after it when every channel is at the top position.
- R13: `seqAbort` stays set through a return to running and clears at the edge that starts the next sequence.
- R14: A `forceOff` pulse in the running state drops all enables at the next edge and takes the block off without setting `seqDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrOnReq | input | 1 | Power-on request level |
| swOffCmd | input | 1 | Software power-off command pulse |
| forceOff | input | 1 | Immediate shutdown request, honoured only while running |
| chFault | input | NUM_CH | Per-channel fault flags |
| chBelowOff | input | NUM_CH | Per-channel supply-below-OFF-threshold flags |
| chPosFlat | input | NUM_CH*POS_W | Packed sequence position of each channel |
| chOffDlyFlat | input | NUM_CH*DLY_W | Packed off-delay of each channel, in ticks |
| sttSel | input | 2 | Stall timer setting |
| sttOffEn | input | 1 | Enables the stall timer for power-off |
| chEnable | output | NUM_CH | Per-channel supply enable |
| rstOutN | output | 1 | Active-low system reset |
| healthy | output | 1 | Supplies-good status |
| seqDone | output | 1 | All sequenced channels are off |
| seqAbort | output | 1 | Sequence ended by the stall timer |

## Verification
The bench builds the block with four channels, four positions, a tick every 4 clocks and a stall unit of 5 ticks. With these values the stall limits come to 20, 40 and 80 cycles, so the bench can run all three limits, and both ways of disabling the timer, in a few hundred cycles each. Four positions let it check the exact one-cycle cost of each empty position and a strict top-down order across every channel. Delays of a few ticks make the 8-tick spacing between two members of one position visible within a tight window.

// File: rtl/pwroff_seq_pkg.sv
package pwroff_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_ENTER = 2'd2,
    ST_WAIT  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startSeq;   // point at the top position
    logic loadPos;    // load member delays, restart stall timer
    logic decPos;     // step to the next lower position
    logic runTimers;  // count delays and stall timer on ticks
    logic dropAll;    // clear every enable
    logic raiseAll;   // set every enable
  } seqStrobe_t;

  // stall timer scale, in units
  function automatic int unsigned sttScale(input logic [1:0] sel);
    case (sel)
      2'd1:    return 1;
      2'd2:    return 2;
      2'd3:    return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwroff_seq_datapath.sv
module pwroff_seq_datapath
  import pwroff_seq_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int NUM_POS      = 8,
  parameter int DLY_W        = 10,
  parameter int CLK_PER_TICK = 250000,
  parameter int STT_UNIT     = 100,
  localparam int POS_W       = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [NUM_CH*POS_W-1:0]   chPosFlat,
  input  logic [NUM_CH*DLY_W-1:0]   chOffDlyFlat,
  input  logic [NUM_CH-1:0]         chBelowOff,
  input  logic [1:0]                sttSel,
  input  logic                      sttOffEn,
  output logic [NUM_CH-1:0]         chEnable,
  output logic                      posEmpty,
  output logic                      posClear,
  output logic                      posIsZero,
  output logic                      sttExpired
);

  localparam int TICK_W   = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int STT_MAX  = 4 * STT_UNIT;
  localparam int TMR_W    = $clog2(STT_MAX + 1);

  // prescaled time base
  logic [TICK_W-1:0] tickCnt;
  logic              tick;

  assign tick = (tickCnt == TICK_W'(CLK_PER_TICK - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // position pointer
  logic [POS_W-1:0] curPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curPos <= '0;
    else if (strobe.startSeq) curPos <= POS_W'(NUM_POS - 1);
    else if (strobe.decPos)   curPos <= curPos - 1'b1;
  end

  assign posIsZero = (curPos == '0);

  // per-channel delay and enable
  logic [NUM_CH-1:0] inPos;
  logic [NUM_CH-1:0] chSettled;
  logic [NUM_CH-1:0] enableQ;
  logic [DLY_W-1:0]  dlyCnt [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [POS_W-1:0] myPos;
    logic [DLY_W-1:0] myDly;
    logic             dlyZero;

    assign myPos   = chPosFlat[g*POS_W +: POS_W];
    assign myDly   = chOffDlyFlat[g*DLY_W +: DLY_W];
    assign inPos[g] = (myPos == curPos);
    assign dlyZero = (dlyCnt[g] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 dlyCnt[g] <= '0;
      else if (strobe.loadPos)                   dlyCnt[g] <= myDly;
      else if (strobe.runTimers && tick && !dlyZero) dlyCnt[g] <= dlyCnt[g] - 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         enableQ[g] <= 1'b0;
      else if (strobe.raiseAll)                          enableQ[g] <= 1'b1;
      else if (strobe.dropAll)                           enableQ[g] <= 1'b0;
      else if (strobe.runTimers && inPos[g] && dlyZero)  enableQ[g] <= 1'b0;
    end

    assign chSettled[g] = !inPos[g] || (!enableQ[g] && chBelowOff[g]);

    AST_DROP_OWN_POS: assert property (@(posedge clk) disable iff (!rstN)
      $fell(enableQ[g]) |-> ($past(strobe.dropAll) || $past(inPos[g]))) // R4
      else $error("enable dropped outside its position");

    AST_DROP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(enableQ[g]) && !$past(strobe.dropAll)) |-> ($past(dlyCnt[g]) == '0)) // R5
      else $error("enable dropped before delay elapsed");
  end

  assign chEnable = enableQ;
  assign posEmpty = ~|inPos;
  assign posClear = &chSettled;

  // stall timer
  logic [TMR_W-1:0] sttCnt;
  logic [TMR_W-1:0] sttLimit;
  logic             sttArmed;

  assign sttLimit   = TMR_W'(STT_UNIT * sttScale(sttSel));
  assign sttArmed   = sttOffEn && (sttSel != 2'd0);
  assign sttExpired = sttArmed && (sttCnt >= sttLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          sttCnt <= '0;
    else if (strobe.loadPos)                            sttCnt <= '0;
    else if (strobe.runTimers && tick && sttCnt < sttLimit) sttCnt <= sttCnt + 1'b1;
  end

  AST_POS_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (curPos != $past(curPos)) |-> ($past(strobe.startSeq) || (curPos == $past(curPos) - 1'b1))) // R4
    else $error("position moved other than one step down");

  AST_ADVANCE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decPos && !posEmpty) |-> posClear) // R6
    else $error("advanced with an unsettled channel");

  AST_STT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sttCnt <= TMR_W'(STT_MAX)) // R8
    else $error("stall timer beyond largest limit");

endmodule

// File: rtl/pwroff_seq_ctrl.sv
module pwroff_seq_ctrl
  import pwroff_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOnReq,
  input  logic       swOffCmd,
  input  logic       anyFault,
  input  logic       forceOff,
  input  logic       posEmpty,
  input  logic       posClear,
  input  logic       posIsZero,
  input  logic       sttExpired,
  output seqStrobe_t strobe,
  output logic       rstOutN,
  output logic       healthy,
  output logic       seqDone,
  output logic       seqAbort
);

  seqState_t state, nextState;
  logic      pwrOnPrev;
  logic      pwrOnRise;
  logic      finish;
  logic      abortSet;

  assign pwrOnRise = pwrOnReq && !pwrOnPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrOnPrev <= 1'b0;
    else       pwrOnPrev <= pwrOnReq;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    finish    = 1'b0;
    abortSet  = 1'b0;
    case (state)
      ST_OFF: begin
        if (pwrOnRise) begin
          strobe.raiseAll = 1'b1;
          nextState       = ST_ON;
        end
      end
      ST_ON: begin
        if (forceOff) begin
          strobe.dropAll = 1'b1;
          nextState      = ST_OFF;
        end else if (!pwrOnReq || swOffCmd || anyFault) begin
          strobe.startSeq = 1'b1;
          nextState       = ST_ENTER;
        end
      end
      ST_ENTER: begin
        strobe.loadPos = 1'b1;
        if (!posEmpty) begin
          nextState = ST_WAIT;
        end else if (posIsZero) begin
          finish    = 1'b1;
          nextState = ST_OFF;
        end else begin
          strobe.decPos = 1'b1;
        end
      end
      ST_WAIT: begin
        strobe.runTimers = 1'b1;
        if (posClear) begin
          if (posIsZero) begin
            finish    = 1'b1;
            nextState = ST_OFF;
          end else begin
            strobe.decPos = 1'b1;
            nextState     = ST_ENTER;
          end
        end else if (sttExpired) begin
          strobe.dropAll = 1'b1;
          abortSet       = 1'b1;
          nextState      = ST_OFF;
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  seqDone <= 1'b0;
    else if (finish)                            seqDone <= 1'b1;
    else if (strobe.raiseAll || strobe.startSeq) seqDone <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seqAbort <= 1'b0;
    else if (abortSet)        seqAbort <= 1'b1;
    else if (strobe.startSeq) seqAbort <= 1'b0;
  end

  assign rstOutN = (state == ST_ON);
  assign healthy = (state == ST_ON);

  AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && seqAbort)) // R11
    else $error("done and abort both set");

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqAbort) |-> $past(state == ST_ON)) // R13
    else $error("abort cleared other than at a sequence start");

endmodule

// File: rtl/pwroff_cascade_seq.sv
module pwroff_cascade_seq
  import pwroff_seq_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int NUM_POS      = 8,
  parameter int DLY_W        = 10,
  parameter int CLK_PER_TICK = 250000,
  parameter int STT_UNIT     = 100,
  localparam int POS_W       = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pwrOnReq,
  input  logic                    swOffCmd,
  input  logic                    forceOff,
  input  logic [NUM_CH-1:0]       chFault,
  input  logic [NUM_CH-1:0]       chBelowOff,
  input  logic [NUM_CH*POS_W-1:0] chPosFlat,
  input  logic [NUM_CH*DLY_W-1:0] chOffDlyFlat,
  input  logic [1:0]              sttSel,
  input  logic                    sttOffEn,
  output logic [NUM_CH-1:0]       chEnable,
  output logic                    rstOutN,
  output logic                    healthy,
  output logic                    seqDone,
  output logic                    seqAbort
);

  seqStrobe_t strobe;
  logic       posEmpty;
  logic       posClear;
  logic       posIsZero;
  logic       sttExpired;

  pwroff_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrOnReq   (pwrOnReq),
    .swOffCmd   (swOffCmd),
    .anyFault   (|chFault),
    .forceOff   (forceOff),
    .posEmpty   (posEmpty),
    .posClear   (posClear),
    .posIsZero  (posIsZero),
    .sttExpired (sttExpired),
    .strobe     (strobe),
    .rstOutN    (rstOutN),
    .healthy    (healthy),
    .seqDone    (seqDone),
    .seqAbort   (seqAbort)
  );

  pwroff_seq_datapath #(
    .NUM_CH       (NUM_CH),
    .NUM_POS      (NUM_POS),
    .DLY_W        (DLY_W),
    .CLK_PER_TICK (CLK_PER_TICK),
    .STT_UNIT     (STT_UNIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .chPosFlat    (chPosFlat),
    .chOffDlyFlat (chOffDlyFlat),
    .chBelowOff   (chBelowOff),
    .sttSel       (sttSel),
    .sttOffEn     (sttOffEn),
    .chEnable     (chEnable),
    .posEmpty     (posEmpty),
    .posClear     (posClear),
    .posIsZero    (posIsZero),
    .sttExpired   (sttExpired)
  );

  AST_ABORT_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqAbort) |-> (chEnable == '0)) // R7
    else $error("abort with an enable still high");

  AST_DONE_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (chEnable == '0)) // R11
    else $error("done with an enable still high");

endmodule

// File: tb/sim_pwroff_cascade_seq.sv
module sim_pwroff_cascade_seq;

  localparam int NCH = 4;
  localparam int NPOS = 4;
  localparam int PW = 2;
  localparam int DW = 6;
  localparam int TDIV = 4;
  localparam int UNIT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrOnReq = 1'b0;
  logic swOffCmd = 1'b0;
  logic forceOff = 1'b0;
  logic [NCH-1:0] chFault = '0;
  logic [NCH-1:0] chBelowOff = '0;
  logic [NCH*PW-1:0] chPosFlat = '0;
  logic [NCH*DW-1:0] chOffDlyFlat = '0;
  logic [1:0] sttSel = 2'd0;
  logic sttOffEn = 1'b0;
  logic [NCH-1:0] chEnable;
  logic rstOutN, healthy, seqDone, seqAbort;

  int nChk = 0;
  int nErr = 0;
  int cyc = 0;
  int lag [NCH];
  bit stuck [NCH];
  int offCnt [NCH];
  int dropAt [NCH];
  int belowAt [NCH];
  logic [NCH-1:0] prevEn = '0;
  logic [NCH-1:0] prevBelow = '0;

  always #2 clk = ~clk;

  pwroff_cascade_seq #(
    .NUM_CH(NCH), .NUM_POS(NPOS), .DLY_W(DW), .CLK_PER_TICK(TDIV), .STT_UNIT(UNIT)
  ) u0 (
    .clk(clk), .rstN(rstN), .pwrOnReq(pwrOnReq), .swOffCmd(swOffCmd), .forceOff(forceOff),
    .chFault(chFault), .chBelowOff(chBelowOff), .chPosFlat(chPosFlat),
    .chOffDlyFlat(chOffDlyFlat), .sttSel(sttSel), .sttOffEn(sttOffEn),
    .chEnable(chEnable), .rstOutN(rstOutN), .healthy(healthy),
    .seqDone(seqDone), .seqAbort(seqAbort)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // supply model: drops below threshold some cycles after its enable falls
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (chEnable[i]) begin
        offCnt[i] = 0;
        chBelowOff[i] = 1'b0;
      end else if (!stuck[i]) begin
        offCnt[i] = offCnt[i] + 1;
        if (offCnt[i] >= lag[i]) chBelowOff[i] = 1'b1;
      end
      if (prevEn[i] && !chEnable[i]) dropAt[i] = cyc;
      if (!prevBelow[i] && chBelowOff[i]) belowAt[i] = cyc;
    end
    prevEn = chEnable;
    prevBelow = chBelowOff;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int p0, p1, p2, p3, input int d0, d1, d2, d3);
    chPosFlat = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    chOffDlyFlat = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    for (int i = 0; i < NCH; i++) begin
      lag[i] = 3; stuck[i] = 0; dropAt[i] = -1; belowAt[i] = -1;
    end
  endtask

  task automatic waitEnd(input int maxCyc);
    for (int n = 0; n < maxCyc; n++) begin
      @(negedge clk);
      if (seqDone || seqAbort) break;
    end
  endtask

  task automatic powerOn(input string req);
    @(negedge clk); pwrOnReq = 1'b0;
    repeat (2) @(negedge clk);
    pwrOnReq = 1'b1;
    repeat (2) @(negedge clk);
    chk({req, " R2 enables"}, int'(chEnable), 'hF);
    chk({req, " R2 rstOutN"}, int'(rstOutN), 1);
    chk({req, " R2 healthy"}, int'(healthy), 1);
    chk({req, " R11 done cleared"}, int'(seqDone), 0);
  endtask

  task automatic t_reset();
    chk("R1 enables", int'(chEnable), 0);
    chk("R1 rstOutN", int'(rstOutN), 0);
    chk("R1 healthy", int'(healthy), 0);
    chk("R1 done", int'(seqDone), 0);
    chk("R1 abort", int'(seqAbort), 0);
  endtask

  // R12: empty positions cost one cycle each
  task automatic t_skip(input int pos, input int expEdges);
    int n;
    setCfg(pos, pos, pos, pos, 0, 0, 0, 0);
    powerOn("skip");
    pwrOnReq = 1'b0;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) begin
        chk("R3 level trigger rstOutN", int'(rstOutN), 0);
        chk("R9 healthy low", int'(healthy), 0);
      end
      if (chEnable == '0) break;
    end
    chk("R12 edges to drop", n, expEdges);
    waitEnd(200);
    chk("R11 done", int'(seqDone), 1);
    chk("R11 no abort", int'(seqAbort), 0);
  endtask

  // R4 R6 R10: strict top-down order, gating on below flags, ignored inputs
  task automatic t_order();
    setCfg(0, 1, 2, 3, 1, 1, 1, 1);
    lag[3] = 40;
    powerOn("order");
    swOffCmd = 1'b1;
    @(negedge clk); swOffCmd = 1'b0;
    chk("R3 sw trigger rstOutN", int'(rstOutN), 0);
    repeat (10) @(negedge clk);
    forceOff = 1'b1;
    @(negedge clk); forceOff = 1'b0;
    chk("R10 forceOff ignored ch0", int'(chEnable[0]), 1);
    pwrOnReq = 1'b0;
    @(negedge clk); pwrOnReq = 1'b1;
    @(negedge clk);
    chk("R10 pwrOnReq ignored rstOutN", int'(rstOutN), 0);
    chk("R9 healthy held low", int'(healthy), 0);
    waitEnd(500);
    chk("R11 done", int'(seqDone), 1);
    chk("R4 ch3 before ch2", int'(dropAt[3] < dropAt[2]), 1);
    chk("R4 ch2 before ch1", int'(dropAt[2] < dropAt[1]), 1);
    chk("R4 ch1 before ch0", int'(dropAt[1] < dropAt[0]), 1);
    chk("R6 ch2 waits ch3 below", int'(dropAt[2] > belowAt[3]), 1);
    repeat (5) @(negedge clk);
    chk("R10 no self restart", int'(rstOutN), 0);
  endtask

  // R5: per-channel delay inside one position
  task automatic t_delay();
    int diff;
    setCfg(2, 2, 0, 0, 2, 10, 0, 0);
    powerOn("delay");
    chFault[2] = 1'b1;
    @(negedge clk); chFault[2] = 1'b0;
    chk("R3 fault trigger rstOutN", int'(rstOutN), 0);
    waitEnd(500);
    diff = dropAt[1] - dropAt[0];
    chk("R5 short delay first", int'(dropAt[0] < dropAt[1]), 1);
    chk("R5 spacing 8 ticks", int'(diff >= 8*TDIV - 4 && diff <= 8*TDIV + 4), 1);
    chk("R11 done", int'(seqDone), 1);
  endtask

  // R7 R8 R13: stall abort at each limit
  task automatic t_abort(input int sel, input int scale);
    int n;
    setCfg(0, 3, 0, 0, 0, 0, 0, 0);
    stuck[1] = 1;
    sttSel = 2'(sel); sttOffEn = 1'b1;
    powerOn("abort");
    if (sel != 1) chk("R13 abort kept while running", int'(seqAbort), 1);
    pwrOnReq = 1'b0;
    @(negedge clk);
    chk("R13 abort cleared at start", int'(seqAbort), 0);
    n = 1;
    for (int k = 0; k < 400; k++) begin
      if (seqAbort) break;
      @(negedge clk); n++;
    end
    chk("R7 abort set", int'(seqAbort), 1);
    chk("R7 all enables low", int'(chEnable), 0);
    chk("R7 no done", int'(seqDone), 0);
    chk("R8 abort latency", int'(n >= UNIT*scale*TDIV - 2 && n <= UNIT*scale*TDIV + 8), 1);
  endtask

  // R8: timer off through either control
  task automatic t_noTimer(input int sel, input bit en);
    setCfg(0, 3, 0, 0, 0, 0, 0, 0);
    stuck[1] = 1;
    sttSel = 2'(sel); sttOffEn = en;
    powerOn("notimer");
    pwrOnReq = 1'b0;
    repeat (150) @(negedge clk);
    chk("R8 disabled no abort", int'(seqAbort), 0);
    chk("R8 still sequencing", int'(rstOutN), 0);
    chk("R8 stalled not done", int'(seqDone), 0);
    stuck[1] = 0;
    waitEnd(200);
    chk("R8 finishes after release", int'(seqDone), 1);
  endtask

  // R14: immediate shutdown while running
  task automatic t_force();
    setCfg(0, 1, 2, 3, 5, 5, 5, 5);
    powerOn("force");
    forceOff = 1'b1;
    @(negedge clk); forceOff = 1'b0;
    chk("R14 enables low", int'(chEnable), 0);
    chk("R14 rstOutN low", int'(rstOutN), 0);
    chk("R14 no done", int'(seqDone), 0);
    chk("R14 no abort", int'(seqAbort), 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      lag[i] = 3; stuck[i] = 0; offCnt[i] = 0; dropAt[i] = -1; belowAt[i] = -1;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_skip(0, 6);
    t_skip(3, 3);
    t_order();
    t_delay();
    t_abort(1, 1);
    t_abort(2, 2);
    t_abort(3, 4);
    t_noTimer(0, 1'b1);
    t_noTimer(1, 1'b0);
    t_force();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule